// File: doc/BRIEF.md
# Link Power Supervisor

This block watches the power-good indication coming back from the link-layer device and shuts down the PHY side of the PHY/link interface in two steps when that indication stays low. A low-duration counter runs in the interface clock domain. After a short timeout it puts the interface into reset and tells the pad logic to drive the 8-bit data bus and the 2-bit control bus low. After a longer timeout it also turns off the interface clock sent to the link. That clock is gated through a latch, so it stops at logic low and never emits a shortened pulse.

When the power-good indication comes back, the clock starts again first. The interface reset is then held for one more cycle, so the link sees at least one full clock edge while it is still in reset. Both thresholds are given in interface clock cycles. With the 49.152 MHz interface clock, the defaults of 59 and 123 cycles match roughly 1.2 µs and 2.5 µs.

Top module: `linkpwr_supervisor`

## Requirements
- R1: While rst_n is low and just after it is released, with link_pwr_ok high, intf_rst, dat_hold_low and ctl_hold_low read 0 and link_clk_en reads 1.
- R2: link_pwr_ok passes through two synchronising flops. If it is sampled low on N consecutive rising edges numbered 1..N and N >= RST_CYC (default 59), intf_rst goes high after edge RST_CYC+2. It stays low for any N < RST_CYC.
- R3: dat_hold_low and ctl_hold_low are high in exactly the cycles in which intf_rst is high (1 = drive the bus low).
- R4: If link_pwr_ok is sampled low on N >= STOP_CYC (default 123) consecutive edges, link_clk_en goes low after edge STOP_CYC+2. It stays high for any N < STOP_CYC.
- R5: One edge that samples link_pwr_ok high clears the low-duration count. Two low runs that are each shorter than RST_CYC never assert intf_rst, even when they are separated by a single high sample.
- R6: After a low run of N edges that asserted intf_rst, link_clk_en is high again after edge N+3 and intf_rst falls after edge N+4. The clock therefore resumes one cycle before the reset releases.
- R7: While link_clk_en is high, link_clk follows clk. The rising edge on which link_clk_en falls still produces a full high phase on link_clk. From the next high phase on, link_clk stays at 0.
- R8: The low-duration count saturates. If link_pwr_ok stays low indefinitely, link_clk_en stays 0 and intf_rst stays 1.
- R9: Asserting rst_n from the clock-stopped condition restores the R1 output values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock (49.152 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| link_pwr_ok | input | 1 | Asynchronous power-good indication from the link device |
| intf_rst | output | 1 | 1 = hold the PHY/link interface in reset |
| dat_hold_low | output | 1 | 1 = drive the 8-bit data bus low |
| ctl_hold_low | output | 1 | 1 = drive the 2-bit control bus low |
| link_clk_en | output | 1 | 1 = interface clock to the link is enabled |
| link_clk | output | 1 | Gated interface clock to the link |

## Verification
A corrupted low-duration count shows up at the ports as a shifted edge: intf_rst or link_clk_en changes one or more cycles away from edge RST_CYC+2 or STOP_CYC+2, or changes for a run that is too short. A state register stuck in the wrong stage shows up within one cycle of power-good returning, either as a reset that releases before the clock resumes or as a clock that does not come back. The bench times every transition to the exact edge against a table of run lengths on both sides of each threshold. It also probes the gated clock during its high phase, so that a runt or missing pulse is caught on the first cycle it occurs.

// File: rtl/linkpwr_pkg.sv
package linkpwr_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_IFRST  = 2'd1,
    ST_CLKOFF = 2'd2,
    ST_RESUME = 2'd3
  } sup_state_t;

endpackage

// File: rtl/linkpwr_sync.sv
module linkpwr_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] stage_q;

  // Stage 0 takes the raw input; every later stage takes the one before it.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_first
        assign d_in = async_i;
      end else begin : g_next
        assign d_in = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= IDLE_VAL;
        else        stage_q[i] <= d_in;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/linkpwr_timer.sv
module linkpwr_timer #(
  parameter int SAT_VAL = 123,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok_s,
  output logic [CW-1:0] low_cnt
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // A high sample clears the count; a low sample advances it until it saturates.
  always_comb begin
    cnt_en = pwr_ok_s || (cnt_q != CW'(SAT_VAL));
    cnt_d  = pwr_ok_s ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign low_cnt = cnt_q;

endmodule

// File: rtl/linkpwr_fsm.sv
module linkpwr_fsm
  import linkpwr_pkg::*;
#(
  parameter int RST_CYC  = 59,
  parameter int STOP_CYC = 123,
  parameter int CW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok_s,
  input  logic [CW-1:0] low_cnt,
  output logic          if_rst,
  output logic          d_low,
  output logic          c_low,
  output logic          ck_en
);

  localparam logic [CW-1:0] RST_HIT  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] STOP_HIT = CW'(STOP_CYC - 1);

  sup_state_t state_q;
  sup_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!pwr_ok_s && low_cnt == RST_HIT) state_d = ST_IFRST;
      end
      ST_IFRST: begin
        if (pwr_ok_s)                  state_d = ST_RESUME;
        else if (low_cnt == STOP_HIT)  state_d = ST_CLKOFF;
      end
      ST_CLKOFF: begin
        if (pwr_ok_s) state_d = ST_RESUME;
      end
      ST_RESUME: begin
        state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    if_rst = (state_q != ST_RUN);
    d_low  = (state_q != ST_RUN);
    c_low  = (state_q != ST_RUN);
    ck_en  = (state_q != ST_CLKOFF);
  end

endmodule

// File: rtl/linkpwr_clkgate.sv
module linkpwr_clkgate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);

  logic en_lat;

  // The enable may only change while the clock is low, so the output has no runt pulse.
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;

endmodule

// File: rtl/linkpwr_supervisor.sv
module linkpwr_supervisor #(
  parameter int RST_CYC     = 59,
  parameter int STOP_CYC    = 123,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_pwr_ok,
  output logic intf_rst,
  output logic dat_hold_low,
  output logic ctl_hold_low,
  output logic link_clk_en,
  output logic link_clk
);

  localparam int CW = $clog2(STOP_CYC + 1);

  logic          lps_sync;
  logic [CW-1:0] low_cnt;

  linkpwr_sync #(
    .STAGES   (SYNC_STAGES),
    .IDLE_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (link_pwr_ok),
    .sync_o  (lps_sync)
  );

  linkpwr_timer #(
    .SAT_VAL (STOP_CYC),
    .CW      (CW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok_s (lps_sync),
    .low_cnt  (low_cnt)
  );

  linkpwr_fsm #(
    .RST_CYC  (RST_CYC),
    .STOP_CYC (STOP_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok_s (lps_sync),
    .low_cnt  (low_cnt),
    .if_rst   (intf_rst),
    .d_low    (dat_hold_low),
    .c_low    (ctl_hold_low),
    .ck_en    (link_clk_en)
  );

  linkpwr_clkgate u_gate (
    .clk_i (clk),
    .en_i  (link_clk_en),
    .clk_o (link_clk)
  );

endmodule

// File: rtl/linkpwr_checker.sv
module linkpwr_checker #(
  parameter int RST_CYC  = 59,
  parameter int STOP_CYC = 123,
  parameter int CW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lps_sync,
  input logic [CW-1:0] low_cnt,
  input logic          intf_rst,
  input logic          dat_hold_low,
  input logic          ctl_hold_low,
  input logic          link_clk_en
);

  // R2
  rst_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intf_rst) |-> $past(low_cnt) == CW'(RST_CYC - 1));

  // R3
  dat_low_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_hold_low) |-> $past(low_cnt) == CW'(RST_CYC - 1));

  // R3
  ctl_low_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_hold_low) |-> $past(low_cnt) == CW'(RST_CYC - 1));

  // R4
  clk_stop_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_clk_en) |-> $past(low_cnt) == CW'(STOP_CYC - 1));

  // R4
  stop_implies_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_clk_en |-> intf_rst);

  // R5
  high_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lps_sync |=> low_cnt == '0);

  // R6
  clk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk_en) |-> intf_rst);

  // R6
  rst_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intf_rst) |-> $past(link_clk_en));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CW'(STOP_CYC));

endmodule

bind linkpwr_supervisor linkpwr_checker #(
  .RST_CYC  (RST_CYC),
  .STOP_CYC (STOP_CYC),
  .CW       (CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lps_sync     (lps_sync),
  .low_cnt      (low_cnt),
  .intf_rst     (intf_rst),
  .dat_hold_low (dat_hold_low),
  .ctl_hold_low (ctl_hold_low),
  .link_clk_en  (link_clk_en)
);

// File: tb/sim_linkpwr_supervisor.sv
`timescale 1ns/1ps
module sim_linkpwr_supervisor;

  logic clk = 1'b0;
  logic rst_n;
  logic link_pwr_ok;
  logic intf_rst, dat_hold_low, ctl_hold_low, link_clk_en, link_clk;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  linkpwr_supervisor u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_pwr_ok  (link_pwr_ok),
    .intf_rst     (intf_rst),
    .dat_hold_low (dat_hold_low),
    .ctl_hold_low (ctl_hold_low),
    .link_clk_en  (link_clk_en),
    .link_clk     (link_clk)
  );

  // low length, reset-on edge, reset-off edge, clock-off edge, clock-on edge (0 = never)
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{  1,  0,   0,   0,   0},
    '{ 30,  0,   0,   0,   0},
    '{ 58,  0,   0,   0,   0},
    '{ 59, 61,  63,   0,   0},
    '{ 60, 61,  64,   0,   0},
    '{100, 61, 104,   0,   0},
    '{122, 61, 126,   0,   0},
    '{123, 61, 127, 125, 126},
    '{150, 61, 154, 125, 153}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    link_pwr_ok = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    link_pwr_ok = 1'b1;
    repeat (3) @(negedge clk);
    // R1: values while reset is applied
    chk("R1 rst during reset", intf_rst, 0);
    chk("R1 clk_en during reset", link_clk_en, 1);
    rst_n = 1'b1;
    idle(4);
    chk("R1 rst after reset", intf_rst, 0);
    chk("R1 hold lows after reset", dat_hold_low | ctl_hold_low, 0);
    chk("R1 clk_en after reset", link_clk_en, 1);

    // R2 R3 R4 R6: table of low-run lengths
    for (int v = 0; v < NV; v++) begin
      int ron, roff, goff, gon, mism;
      ron = 0; roff = 0; goff = 0; gon = 0; mism = 0;
      idle(10);
      for (int e = 1; e <= VEC[v][0] + 8; e++) begin
        link_pwr_ok = (e <= VEC[v][0]) ? 1'b1 - 1'b1 : 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (intf_rst && ron == 0) ron = e;
        if (ron != 0 && !intf_rst && roff == 0) roff = e;
        if (!link_clk_en && goff == 0) goff = e;
        if (goff != 0 && link_clk_en && gon == 0) gon = e;
        if (dat_hold_low !== intf_rst || ctl_hold_low !== intf_rst) mism++;
      end
      chk($sformatf("R2 rst-on len=%0d", VEC[v][0]), ron, VEC[v][1]);
      chk($sformatf("R6 rst-off len=%0d", VEC[v][0]), roff, VEC[v][2]);
      chk($sformatf("R4 clk-off len=%0d", VEC[v][0]), goff, VEC[v][3]);
      chk($sformatf("R6 clk-on len=%0d", VEC[v][0]), gon, VEC[v][4]);
      chk($sformatf("R3 hold-low mismatch len=%0d", VEC[v][0]), mism, 0);
    end

    // R5: a single high sample between two short runs restarts the count
    begin
      int seen;
      seen = 0;
      idle(10);
      for (int e = 1; e <= 120; e++) begin
        link_pwr_ok = (e == 51 || e > 101) ? 1'b1 : 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (intf_rst) seen = 1;
      end
      chk("R5 split short runs no reset", seen, 0);
      seen = 0;
      idle(10);
      for (int e = 1; e <= 130; e++) begin
        link_pwr_ok = (e == 51 || e > 110) ? 1'b1 : 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (intf_rst) seen = 1;
      end
      chk("R5 second run long enough resets", seen, 1);
    end

    // R7: gated clock stops after one full pulse on the disabling edge
    begin
      int first_zero;
      int pulse_at_off;
      first_zero = 0;
      pulse_at_off = 0;
      idle(10);
      @(posedge clk); #1;
      chk("R7 link_clk follows clk when enabled", link_clk, 1);
      @(negedge clk);
      for (int e = 1; e <= 130; e++) begin
        link_pwr_ok = 1'b0;
        @(posedge clk);
        #1;
        if (e == 125) pulse_at_off = link_clk;
        if (!link_clk && first_zero == 0) first_zero = e;
        @(negedge clk);
      end
      chk("R7 full pulse on disabling edge", pulse_at_off, 1);
      chk("R7 first suppressed high phase", first_zero, 126);
    end

    // R8: stays stopped while power-good remains low
    repeat (300) @(negedge clk);
    chk("R8 clk_en stays low", link_clk_en, 0);
    chk("R8 reset stays high", intf_rst, 1);
    @(posedge clk); #1;
    chk("R8 link_clk stays low", link_clk, 0);

    // R9: asynchronous reset from the stopped state
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk("R9 async rst releases intf_rst", intf_rst, 0);
    chk("R9 async rst enables clock", link_clk_en, 1);
    chk("R9 async rst releases hold lows", dat_hold_low | ctl_hold_low, 0);
    @(negedge clk);
    link_pwr_ok = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    chk("R1 after re-reset", intf_rst, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule